// File: doc/BRIEF.md
# Interrupt Enable Flag Controller

This block keeps the processor's interrupt enable state. Two flags are held: `ief1`, the live maskable-interrupt enable, and `ief2`, a saved copy. A nonmaskable interrupt parks `ief1` in `ief2` before it masks, and the matching return brings it back. One-cycle strobes from the instruction sequencer drive all flag updates. When several strobes arrive together, a fixed priority decides which one acts.

The block also holds an 8-bit interrupt register and its 16-bit upper extension. Both load from the sequencer and read back together as one 24-bit word. Three byte-wide control registers sit at fixed on-chip I/O addresses: a per-line request enable mask, a vector base and a trap/break register. The block gates the four external maskable request lines with the enable mask and `ief1` before they go on to the interrupt logic.

Top module: `irq_enable_ctrl`

## Requirements
- R1: A low `rst_n`, or a one-cycle `ev_reset` strobe, leaves `ief1`, `ief2`, the 24-bit `ireg_rd` and all three I/O registers at zero on the next cycle.
- R2: `ev_nmi_ack` loads `ief2` with the prior `ief1` and clears `ief1`.
- R3: `ev_retn` loads `ief1` with the prior `ief2` and leaves `ief2` unchanged.
- R4: `ev_trap` and `ev_int_ack` each clear both flags.
- R5: `ev_ei` sets both flags to 1. `ev_di` clears both flags.
- R6: `ev_reti`, `ev_ret`, `ev_ld_a_i` and `ev_ld_hl_i` leave both flags unchanged. With no flag strobe active, the flags hold.
- R7: Simultaneous strobes resolve in this order, highest first: `ev_reset`, `ev_nmi_ack`, `ev_trap`, `ev_int_ack`, `ev_retn`, `ev_di`, `ev_ei`.
- R8: `pv_flag` equals `ief2` in a cycle where `ev_ld_a_i` is high, and is 0 otherwise.
- R9: `int_fwd[k]` is `int_req[k]` AND bit k of the enable mask AND `ief1`, in the same cycle, for k = 0..3.
- R10: I/O address 0x00000017 holds the 8-bit enable mask, 0x00000018 the vector base and 0x00000019 the trap/break register. A write with `io_wr` takes effect on the next cycle. `io_rdata` shows the addressed register combinationally. Any other address reads 0, and writes to it change no register.
- R11: `ir_wr` loads `ir_wdata` into the low 8 bits. `irx_wr` loads all 24 bits from `irx_wdata`: bits 23:8 go to the extension and bits 7:0 to the register. `irx_wr` wins if both are high. `ireg_rd` is {extension, register}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_reset | input | 1 | Reset event strobe |
| ev_nmi_ack | input | 1 | Nonmaskable acknowledge strobe |
| ev_trap | input | 1 | Trap acknowledge strobe |
| ev_int_ack | input | 1 | Maskable acknowledge strobe |
| ev_retn | input | 1 | Return-from-nonmaskable strobe |
| ev_reti | input | 1 | Return-from-interrupt strobe |
| ev_ret | input | 1 | Plain return strobe |
| ev_ei | input | 1 | Enable-interrupts strobe |
| ev_di | input | 1 | Disable-interrupts strobe |
| ev_ld_a_i | input | 1 | Load-accumulator-from-I strobe |
| ev_ld_hl_i | input | 1 | Load-pair-from-I strobe |
| ir_wr | input | 1 | Write 8-bit interrupt register |
| ir_wdata | input | 8 | Data for ir_wr |
| irx_wr | input | 1 | Write register and extension together |
| irx_wdata | input | 24 | Data for irx_wr |
| ireg_rd | output | 24 | {extension, register} |
| io_addr | input | 32 | On-chip I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| int_req | input | 4 | External maskable requests |
| int_fwd | output | 4 | Gated maskable requests |
| ief1 | output | 1 | Maskable enable flag |
| ief2 | output | 1 | Saved enable flag |
| pv_flag | output | 1 | Parity/overflow value for the load-from-I instruction |

## Verification
The flag properties assume the sequencer pulses each event strobe for one cycle. Each property checks a single strobe, or a strobe combined only with strobes of lower priority, so a property fires only when the strobes above it are quiet. The stimulus table drives exactly one strobe per row, except for rows written to test priority. Those rows pair strobes on purpose, and the properties for the lower-priority strobe stay silent on them because of the same exclusion. Values on `io_addr`, `int_req` and the data buses are unconstrained, and the bench exercises both mapped and unmapped addresses.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef struct packed {
        logic ief1;
        logic ief2;
    } ief_t;

    typedef struct packed {
        logic rst;
        logic nmi;
        logic trap;
        logic iack;
        logic retn;
        logic ei;
        logic di;
    } flag_ev_t;

endpackage

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  flag_ev_t ev,
    output ief_t     flags
);
    ief_t f_d, f_q;

    // Fixed priority: reset, nmi, trap, int ack, retn, di, ei
    always_comb begin
        f_d = f_q;
        if (ev.rst) begin
            f_d = '0;
        end else if (ev.nmi) begin
            f_d.ief2 = f_q.ief1;
            f_d.ief1 = 1'b0;
        end else if (ev.trap || ev.iack) begin
            f_d = '0;
        end else if (ev.retn) begin
            f_d.ief1 = f_q.ief2;
        end else if (ev.di) begin
            f_d = '0;
        end else if (ev.ei) begin
            f_d = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;
endmodule

// File: rtl/irq_ireg_unit.sv
module irq_ireg_unit #(
    parameter int IR_W  = 8,
    parameter int IRX_W = 16,
    localparam int TOT_W = IR_W + IRX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ir_wr,
    input  logic [IR_W-1:0]  ir_wdata,
    input  logic             irx_wr,
    input  logic [TOT_W-1:0] irx_wdata,
    output logic [TOT_W-1:0] rd
);
    typedef struct packed {
        logic [IRX_W-1:0] ext;
        logic [IR_W-1:0]  base;
    } ireg_t;

    ireg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr)         r_d = '0;
        else if (irx_wr) r_d = irx_wdata;
        else if (ir_wr)  r_d.base = ir_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd = r_q;
endmodule

// File: rtl/irq_io_regs.sv
module irq_io_regs #(
    parameter int          AW       = 32,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] ADDR_EN  = 32'h0000_0017,
    parameter logic [AW-1:0] ADDR_VEC = 32'h0000_0018,
    parameter logic [AW-1:0] ADDR_TBK = 32'h0000_0019
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] en_mask
);
    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] vec;
        logic [DW-1:0] tbk;
    } io_t;

    io_t s_d, s_q;
    logic hit_en, hit_vec, hit_tbk;

    assign hit_en  = (addr == ADDR_EN);
    assign hit_vec = (addr == ADDR_VEC);
    assign hit_tbk = (addr == ADDR_TBK);

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (wr) begin
            if (hit_en)  s_d.en  = wdata;
            if (hit_vec) s_d.vec = wdata;
            if (hit_tbk) s_d.tbk = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        if (hit_en)  rdata = s_q.en;
        if (hit_vec) rdata = s_q.vec;
        if (hit_tbk) rdata = s_q.tbk;
    end

    assign en_mask = s_q.en;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_INT = 4,
    parameter int IR_W    = 8,
    parameter int IRX_W   = 16,
    parameter int IO_AW   = 32,
    parameter int IO_DW   = 8,
    localparam int TOT_W  = IR_W + IRX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_reset,
    input  logic               ev_nmi_ack,
    input  logic               ev_trap,
    input  logic               ev_int_ack,
    input  logic               ev_retn,
    input  logic               ev_reti,
    input  logic               ev_ret,
    input  logic               ev_ei,
    input  logic               ev_di,
    input  logic               ev_ld_a_i,
    input  logic               ev_ld_hl_i,
    input  logic               ir_wr,
    input  logic [IR_W-1:0]    ir_wdata,
    input  logic               irx_wr,
    input  logic [TOT_W-1:0]   irx_wdata,
    output logic [TOT_W-1:0]   ireg_rd,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic               io_wr,
    input  logic [IO_DW-1:0]   io_wdata,
    output logic [IO_DW-1:0]   io_rdata,
    input  logic [NUM_INT-1:0] int_req,
    output logic [NUM_INT-1:0] int_fwd,
    output logic               ief1,
    output logic               ief2,
    output logic               pv_flag
);
    flag_ev_t ev;
    ief_t flags;
    logic [IO_DW-1:0] en_mask;
    logic unused_evts;

    assign ev = '{rst: ev_reset, nmi: ev_nmi_ack, trap: ev_trap,
                  iack: ev_int_ack, retn: ev_retn, ei: ev_ei, di: ev_di};

    // these instructions do not touch the flags
    assign unused_evts = ^{ev_reti, ev_ret, ev_ld_hl_i};

    irq_flag_unit u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .flags (flags)
    );

    irq_ireg_unit #(.IR_W(IR_W), .IRX_W(IRX_W)) u_ireg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ev_reset),
        .ir_wr     (ir_wr),
        .ir_wdata  (ir_wdata),
        .irx_wr    (irx_wr),
        .irx_wdata (irx_wdata),
        .rd        (ireg_rd)
    );

    irq_io_regs #(.AW(IO_AW), .DW(IO_DW)) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ev_reset),
        .addr    (io_addr),
        .wr      (io_wr),
        .wdata   (io_wdata),
        .rdata   (io_rdata),
        .en_mask (en_mask)
    );

    for (genvar k = 0; k < NUM_INT; k++) begin : g_gate
        assign int_fwd[k] = int_req[k] & en_mask[k] & flags.ief1;
    end

    assign ief1    = flags.ief1;
    assign ief2    = flags.ief2;
    assign pv_flag = ev_ld_a_i & flags.ief2;
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk #(
    parameter int NUM_INT = 4,
    parameter int TOT_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ev_reset,
    input logic               ev_nmi_ack,
    input logic               ev_trap,
    input logic               ev_int_ack,
    input logic               ev_retn,
    input logic               ev_ei,
    input logic               ev_di,
    input logic [TOT_W-1:0]   ireg_rd,
    input logic [NUM_INT-1:0] int_req,
    input logic [NUM_INT-1:0] int_fwd,
    input logic               ief1,
    input logic               ief2
);
    logic any_ev;
    assign any_ev = ev_reset | ev_nmi_ack | ev_trap | ev_int_ack | ev_retn | ev_ei | ev_di;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reset |=> (!ief1 && !ief2 && ireg_rd == '0));

    p_nmi_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nmi_ack && !ev_reset) |=> (!ief1 && ief2 == $past(ief1)));

    p_retn_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_retn && !ev_reset && !ev_nmi_ack && !ev_trap && !ev_int_ack)
        |=> (ief1 == $past(ief2) && $stable(ief2)));

    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_trap || ev_int_ack) && !ev_reset && !ev_nmi_ack) |=> (!ief1 && !ief2));

    p_ei_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ei && !ev_reset && !ev_nmi_ack && !ev_trap && !ev_int_ack && !ev_retn && !ev_di)
        |=> (ief1 && ief2));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> ($stable(ief1) && $stable(ief2)));

    p_fwd_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_fwd & ~int_req) == '0) && (ief1 || int_fwd == '0));
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk #(.NUM_INT(NUM_INT), .TOT_W(TOT_W)) u_chk (.*);

// File: tb/tb_irq_enable_ctrl.sv
module tb_irq_enable_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_reset = 0, ev_nmi_ack = 0, ev_trap = 0, ev_int_ack = 0, ev_retn = 0;
    logic ev_reti = 0, ev_ret = 0, ev_ei = 0, ev_di = 0, ev_ld_a_i = 0, ev_ld_hl_i = 0;
    logic ir_wr = 0, irx_wr = 0, io_wr = 0;
    logic [7:0]  ir_wdata = '0, io_wdata = '0, io_rdata;
    logic [23:0] irx_wdata = '0, ireg_rd;
    logic [31:0] io_addr = '0;
    logic [3:0]  int_req = '0, int_fwd;
    logic ief1, ief2, pv_flag;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    irq_enable_ctrl dut (.*);

    // event bits: 10 reset,9 nmi,8 trap,7 iack,6 retn,5 reti,4 ret,3 ei,2 di,1 ldai,0 ldhli
    // entry = {events[10:0], exp ief1, exp ief2}
    localparam logic [12:0] VEC [0:18] = '{
        {11'b000_0000_1000, 2'b11},  // R5 EI
        {11'b010_0000_0000, 2'b01},  // R2 NMI
        {11'b000_0100_0000, 2'b11},  // R3 RETN
        {11'b000_0000_0100, 2'b00},  // R5 DI
        {11'b000_0100_0000, 2'b00},  // R3 RETN from 0
        {11'b000_0000_1000, 2'b11},  // R5 EI
        {11'b000_0010_0000, 2'b11},  // R6 RETI
        {11'b000_0001_0000, 2'b11},  // R6 RET
        {11'b000_0000_0010, 2'b11},  // R6 LD A,I
        {11'b000_0000_0001, 2'b11},  // R6 LD HL,I
        {11'b000_1000_0000, 2'b00},  // R4 INT ack
        {11'b000_0000_1000, 2'b11},  // R5 EI
        {11'b001_0000_0000, 2'b00},  // R4 trap
        {11'b010_0000_0000, 2'b00},  // R2 NMI with ief1=0
        {11'b000_0000_1000, 2'b11},  // R5 EI
        {11'b011_0000_0000, 2'b01},  // R7 NMI over trap
        {11'b000_0000_1100, 2'b00},  // R7 DI over EI
        {11'b000_0000_1000, 2'b11},  // R5 EI
        {11'b100_0000_1000, 2'b00}   // R7 reset over EI
    };

    task automatic drive_ev(input logic [10:0] e);
        {ev_reset, ev_nmi_ack, ev_trap, ev_int_ack, ev_retn, ev_reti,
         ev_ret, ev_ei, ev_di, ev_ld_a_i, ev_ld_hl_i} = e;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [10:0] e);
        @(negedge clk);
        drive_ev(e);
        @(negedge clk);
        drive_ev('0);
    endtask

    task automatic io_write(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 ief1 rst", {31'd0, ief1}, 0);
        check("R1 ief2 rst", {31'd0, ief2}, 0);
        check("R1 ireg rst", {8'd0, ireg_rd}, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < 19; i++) begin
            pulse(VEC[i][12:2]);
            check($sformatf("R2-7 row %0d ief1", i), {31'd0, ief1}, {31'd0, VEC[i][1]});
            check($sformatf("R2-7 row %0d ief2", i), {31'd0, ief2}, {31'd0, VEC[i][0]});
        end

        // R8 pv flag
        pulse(11'b000_0000_1000);             // EI
        @(negedge clk);
        ev_ld_a_i = 1; #1;
        check("R8 pv with ief2=1", {31'd0, pv_flag}, 1);
        ev_ld_a_i = 0; #1;
        check("R8 pv without strobe", {31'd0, pv_flag}, 0);
        pulse(11'b010_0000_0000);             // NMI: ief1=0, ief2=1
        pulse(11'b000_0000_0100);             // DI: both 0
        ev_ld_a_i = 1; #1;
        check("R8 pv with ief2=0", {31'd0, pv_flag}, 0);
        ev_ld_a_i = 0;

        // R10 I/O registers
        io_write(32'h17, 8'h0A);
        io_write(32'h18, 8'h3C);
        io_write(32'h19, 8'hC5);
        io_write(32'h20, 8'hFF);
        io_write(32'h117, 8'h55);
        io_addr = 32'h17; #1;
        check("R10 enable reg", {24'd0, io_rdata}, 32'h0A);
        io_addr = 32'h18; #1;
        check("R10 vector base", {24'd0, io_rdata}, 32'h3C);
        io_addr = 32'h19; #1;
        check("R10 trap/break", {24'd0, io_rdata}, 32'hC5);
        io_addr = 32'h20; #1;
        check("R10 unmapped reads 0", {24'd0, io_rdata}, 0);

        // R9 gating
        int_req = 4'hF; #1;
        check("R9 gated off by ief1", {28'd0, int_fwd}, 0);
        pulse(11'b000_0000_1000);             // EI
        #1;
        check("R9 mask 0A", {28'd0, int_fwd}, 32'hA);
        int_req = 4'h6; #1;
        check("R9 req 6", {28'd0, int_fwd}, 32'h2);
        int_req = 4'hF;
        pulse(11'b000_1000_0000);             // INT ack clears
        #1;
        check("R9 after ack", {28'd0, int_fwd}, 0);
        int_req = 4'h0;

        // R11 interrupt register
        @(negedge clk); ir_wr = 1; ir_wdata = 8'h5C;
        @(negedge clk); ir_wr = 0;
        check("R11 LD I,A", {8'd0, ireg_rd}, 32'h00005C);
        irx_wr = 1; irx_wdata = 24'hABCD12;
        @(negedge clk); irx_wr = 0;
        check("R11 LD I,HL", {8'd0, ireg_rd}, 32'hABCD12);
        ir_wr = 1; ir_wdata = 8'h77;
        @(negedge clk); ir_wr = 0;
        check("R11 low byte only", {8'd0, ireg_rd}, 32'hABCD77);
        ir_wr = 1; irx_wr = 1; ir_wdata = 8'h11; irx_wdata = 24'h123456;
        @(negedge clk); ir_wr = 0; irx_wr = 0;
        check("R11 irx_wr wins", {8'd0, ireg_rd}, 32'h123456);

        // R1 reset strobe clears everything
        pulse(11'b000_0000_1000);             // EI
        pulse(11'b100_0000_0000);             // reset strobe
        check("R1 strobe ireg", {8'd0, ireg_rd}, 0);
        check("R1 strobe flags", {30'd0, ief1, ief2}, 0);
        io_addr = 32'h19; #1;
        check("R1 strobe io", {24'd0, io_rdata}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule